// File: doc/BRIEF.md
# Byte Mailbox Cell

This block holds a single byte passed between a producing agent and a consuming agent that run on the same core clock. One side, typically an 8-bit I/O bus, and the other, a host processor, exchange bytes through it. The producer raises a put strobe together with a byte. The consumer raises a take strobe and finds the byte on a read port. A chip uses several copies of the cell: one per direction and per channel (data or control).

Since the cell holds one entry, its "holding data" and "full" indications always agree, and both are reported. One of the two sides is named the bus side by a parameter. Every strobe from that side sends a one-cycle event pulse toward the host interrupt logic, and this includes strobes that are errors. Misuse has a defined outcome:
- A put to a full cell is discarded and sets a sticky overflow flag.
- A take from an empty cell returns the last byte stored and changes no state.

Reset is asserted asynchronously and released synchronously inside the cell.

Top module: `byte_mailbox`

## Requirements
- R1: After reset, has_data, is_full, ovf_flag and host_event are 0 and take_byte reads 0.
- R2: A put to an empty cell stores put_byte. From the next cycle, has_data and is_full are both 1 and take_byte equals that byte.
- R3: While the cell is full, take_byte presents the stored byte combinationally. A take without a put in that cycle clears has_data and is_full at the next edge.
- R4: host_event is 1 in the cycle after each cycle in which the bus-side strobe is high, and 0 otherwise. BUS_SIDE_PUT=1 makes put_valid the bus-side strobe; BUS_SIDE_PUT=0 makes take_valid the bus-side strobe. This holds whether or not the access is an error.
- R5: A put to a full cell without a take in the same cycle is discarded. The stored byte is unchanged and the cell stays full.
- R6: The discarded put of R5 sets ovf_flag on the next cycle. ovf_flag then stays 1 until reset.
- R7: A take from an empty cell without a put returns the last stored byte (0 after reset). It leaves has_data, is_full and ovf_flag unchanged.
- R8: A put and a take in the same cycle on a full cell act as take-then-put. The take sees the old byte, the new byte is stored, the cell stays full, and ovf_flag is not set.
- R9: A put and a take in the same cycle on an empty cell store the put byte. The take is treated as an empty take, and the cell is full afterwards.
- R10: Driving rst_n low clears has_data, is_full, ovf_flag and take_byte at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| put_valid | input | 1 | Producer strobe, one byte per high cycle |
| put_byte | input | WIDTH | Byte offered by the producer |
| take_valid | input | 1 | Consumer strobe, one byte per high cycle |
| take_byte | output | WIDTH | Stored byte, valid during the take cycle |
| has_data | output | 1 | Cell holds a byte |
| is_full | output | 1 | Cell cannot accept a further byte |
| ovf_flag | output | 1 | Sticky: a put was discarded |
| host_event | output | 1 | One-cycle pulse after each bus-side strobe |

## Verification
The bench builds the cell with WIDTH=4 in two copies that share all inputs, one with BUS_SIDE_PUT=1 and one with BUS_SIDE_PUT=0. Both event polarities are therefore checked against the same stimulus. The narrow width lets the sweep cover every byte value for every pairing of occupancy (empty or full) and strobe pattern (none, put, take, both). This reaches each error path, the same-cycle orderings and the sticky overflow. A reset is then asserted mid-run and checked before any clock edge.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,
    OP_FILL  = 3'd1,
    OP_DRAIN = 3'd2,
    OP_SWAP  = 3'd3,
    OP_DROP  = 3'd4,
    OP_DRY   = 3'd5
  } mbx_op_e;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

endmodule

// File: rtl/mbx_op_decode.sv
module mbx_op_decode
  import mbx_pkg::*;
(
  input  logic occ,
  input  logic put,
  input  logic take,
  output logic load_en,
  output logic occ_next,
  output logic ovf_set
);

  mbx_op_e op;

  always_comb begin
    op = OP_IDLE;
    if (occ) begin
      if (put && take)  op = OP_SWAP;
      else if (take)    op = OP_DRAIN;
      else if (put)     op = OP_DROP;
    end else begin
      if (put)          op = OP_FILL;
      else if (take)    op = OP_DRY;
    end
  end

  always_comb begin
    load_en  = 1'b0;
    occ_next = occ;
    ovf_set  = 1'b0;
    case (op)
      OP_FILL:  begin load_en = 1'b1; occ_next = 1'b1; end
      OP_SWAP:  begin load_en = 1'b1; occ_next = 1'b1; end
      OP_DRAIN: occ_next = 1'b0;
      OP_DROP:  ovf_set = 1'b1;
      default:  ;
    endcase
  end

endmodule

// File: rtl/mbx_store.sv
module mbx_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_next;

  always_comb begin
    q_next = load_en ? d : q_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_next;
  end

  assign q = q_r;

endmodule

// File: rtl/mbx_state.sv
module mbx_state (
  input  logic clk,
  input  logic rst_n,
  input  logic occ_next,
  input  logic ovf_set,
  input  logic evt_next,
  output logic occ,
  output logic ovf,
  output logic evt
);

  logic occ_r, ovf_r, evt_r;
  logic ovf_next;

  always_comb begin
    ovf_next = ovf_r | ovf_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_r <= 1'b0;
      ovf_r <= 1'b0;
      evt_r <= 1'b0;
    end else begin
      occ_r <= occ_next;
      ovf_r <= ovf_next;
      evt_r <= evt_next;
    end
  end

  assign occ = occ_r;
  assign ovf = ovf_r;
  assign evt = evt_r;

  AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n) ovf_set |=> ovf); // R6
  AST_OVF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf); // R6

endmodule

// File: rtl/byte_mailbox.sv
module byte_mailbox #(
  parameter int WIDTH        = 8,
  parameter bit BUS_SIDE_PUT = 1'b1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             put_valid,
  input  logic [WIDTH-1:0] put_byte,
  input  logic             take_valid,
  output logic [WIDTH-1:0] take_byte,
  output logic             has_data,
  output logic             is_full,
  output logic             ovf_flag,
  output logic             host_event
);

  logic rst_core_n;
  logic occ, load_en, occ_next, ovf_set, bus_strobe;

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_core_n)
  );

  generate
    if (BUS_SIDE_PUT) begin : g_bus_put
      assign bus_strobe = put_valid;
    end else begin : g_bus_take
      assign bus_strobe = take_valid;
    end
  endgenerate

  mbx_op_decode u_dec (
    .occ      (occ),
    .put      (put_valid),
    .take     (take_valid),
    .load_en  (load_en),
    .occ_next (occ_next),
    .ovf_set  (ovf_set)
  );

  mbx_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_en (load_en),
    .d       (put_byte),
    .q       (take_byte)
  );

  mbx_state u_state (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .occ_next (occ_next),
    .ovf_set  (ovf_set),
    .evt_next (bus_strobe),
    .occ      (occ),
    .ovf      (ovf_flag),
    .evt      (host_event)
  );

  assign has_data = occ;
  assign is_full  = occ;

  AST_FILL_STORES: assert property (@(posedge clk) disable iff (!rst_core_n) put_valid && !is_full |=> is_full && has_data && take_byte == $past(put_byte)); // R2
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_core_n) take_valid && is_full && !put_valid |=> !is_full && !has_data); // R3
  AST_EVENT_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_core_n) bus_strobe |=> host_event); // R4
  AST_EVENT_QUIET: assert property (@(posedge clk) disable iff (!rst_core_n) !bus_strobe |=> !host_event); // R4
  AST_DROP_KEEPS: assert property (@(posedge clk) disable iff (!rst_core_n) put_valid && is_full && !take_valid |=> is_full && $stable(take_byte)); // R5
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_core_n) put_valid && is_full && !take_valid |=> ovf_flag); // R6
  AST_DRY_TAKE: assert property (@(posedge clk) disable iff (!rst_core_n) take_valid && !is_full && !put_valid |=> !is_full && $stable(take_byte) && ovf_flag == $past(ovf_flag)); // R7
  AST_SWAP_ORDER: assert property (@(posedge clk) disable iff (!rst_core_n) put_valid && take_valid && is_full |=> is_full && take_byte == $past(put_byte) && ovf_flag == $past(ovf_flag)); // R8
  AST_EMPTY_BOTH: assert property (@(posedge clk) disable iff (!rst_core_n) put_valid && take_valid && !is_full |=> is_full && take_byte == $past(put_byte)); // R9

endmodule

// File: tb/byte_mailbox_tb.sv
`timescale 1ns/1ps
module byte_mailbox_tb;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         put_valid = 1'b0;
  logic [W-1:0] put_byte = '0;
  logic         take_valid = 1'b0;
  logic [W-1:0] tb_a, tb_b;
  logic         hd_a, hd_b, fl_a, fl_b, ov_a, ov_b, ev_a, ev_b;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic         m_full;
  logic [W-1:0] m_data;
  logic         m_ovf;

  always #2.5 clk = ~clk;

  byte_mailbox #(.WIDTH(W), .BUS_SIDE_PUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .put_valid(put_valid), .put_byte(put_byte),
    .take_valid(take_valid), .take_byte(tb_a), .has_data(hd_a),
    .is_full(fl_a), .ovf_flag(ov_a), .host_event(ev_a)
  );

  byte_mailbox #(.WIDTH(W), .BUS_SIDE_PUT(1'b0)) u_dut_rd (
    .clk(clk), .rst_n(rst_n), .put_valid(put_valid), .put_byte(put_byte),
    .take_valid(take_valid), .take_byte(tb_b), .has_data(hd_b),
    .is_full(fl_b), .ovf_flag(ov_b), .host_event(ev_b)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req);
    chk({req, " has_data"}, hd_a, m_full);
    chk({req, " has_data rd"}, hd_b, m_full);
    chk({req, " is_full"}, fl_a, m_full);
    chk({req, " is_full rd"}, fl_b, m_full);
    chk({req, " ovf_flag"}, ov_a, m_ovf);
    chk({req, " ovf_flag rd"}, ov_b, m_ovf);
    chk({req, " take_byte"}, tb_a, m_data);
    chk({req, " take_byte rd"}, tb_b, m_data);
  endtask

  // One cycle of stimulus, applied at a falling edge; results checked at the next one.
  task automatic step(input logic w, input logic r, input logic [W-1:0] d);
    string tag;
    put_valid  = w;
    put_byte   = d;
    take_valid = r;
    #1;
    if (r) begin
      // R3 R7 R8: the take sees the byte held before the edge
      chk("R3/R7 take value", tb_a, m_data);
      chk("R3/R7 take value rd", tb_b, m_data);
    end
    if (m_full) begin
      if (w && r)      begin tag = "R8"; m_data = d; end
      else if (r)      begin tag = "R3"; m_full = 1'b0; end
      else if (w)      begin tag = "R5/R6"; m_ovf = 1'b1; end
      else             tag = "R2 hold";
    end else begin
      if (w && r)      begin tag = "R9"; m_full = 1'b1; m_data = d; end
      else if (w)      begin tag = "R2"; m_full = 1'b1; m_data = d; end
      else if (r)      tag = "R7";
      else             tag = "R1 idle";
    end
    @(posedge clk);
    @(negedge clk);
    chk_state(tag);
    chk("R4 event put-side", ev_a, w);
    chk("R4 event take-side", ev_b, r);
  endtask

  task automatic do_reset();
    @(negedge clk);
    put_valid = 1'b0; take_valid = 1'b0; put_byte = '0;
    rst_n = 1'b0;
    #1;
    m_full = 1'b0; m_data = '0; m_ovf = 1'b0;
    chk_state("R10 async clear");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    m_full = 1'b0; m_data = '0; m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk_state("R1 reset");
    chk("R1 event", ev_a, 0);
    chk("R1 event rd", ev_b, 0);

    step(1'b0, 1'b1, 4'h9);   // R7: empty take after reset returns 0

    for (int st = 0; st < 2; st++) begin
      for (int op = 0; op < 4; op++) begin
        for (int v = 0; v < (1 << W); v++) begin
          if (st == 1) begin
            if (m_full) step(1'b0, 1'b1, '0);
            step(1'b1, 1'b0, W'((v * 7 + 3) % (1 << W)));
          end else if (m_full) begin
            step(1'b0, 1'b1, '0);
          end
          step(op[0], op[1], W'(v));
        end
      end
    end

    // R6: overflow persists across further traffic
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b0, '0);
    chk("R6 sticky", ov_a, 1);

    // R10 then R1 again: reset clears the sticky flag
    step(1'b1, 1'b0, 4'hA);
    do_reset();
    chk_state("R1 after reset");
    step(1'b1, 1'b0, 4'h5);
    step(1'b1, 1'b1, 4'hC);
    step(1'b0, 1'b1, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule